// File: doc/BRIEF.md
# Program Counter Sequencer with Interrupt Vectoring

This block holds the 10-bit program counter of a small controller core. It also holds the return-address stack and the interrupt acceptance logic. Each clock, a decoder outside the block asks for one flow action: step, jump, call, return, or return-from-interrupt. The block updates the counter and the stack to match.

Two interrupt sources feed the block. One is an external request pin, which is edge-detected. The other is a timer overflow pulse. Each source sets a pending flag. A pending request is accepted only when three things hold: the global enable is set, that source's own enable is set, and the stack has a free slot. On acceptance the block saves the current counter, jumps to a fixed vector for that source, clears the global enable and clears the serviced flag.

The stack is shallow, two entries by default. A call made while it is full is refused and recorded in a sticky error flag.

Top module: `pc_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, pc is 000H, stack_full is 0, push_err is 0, gie is 0 and neither pending flag is set.
- R2: With no other action requested, inc raises pc by one, wrapping from 3FFH to 000H. jmp loads pc with target, and jmp wins over inc. With no action requested, pc holds.
- R3: call stores pc+1 on the stack and loads target. ret loads pc from the most recent stack entry and removes it. Entries come back last-in, first-out.
- R4: stack_full is 1 exactly when the stack holds DEPTH (2) entries. A call made while the stack is full leaves pc and the stack unchanged and sets push_err, which stays at 1 until reset.
- R5: A ret or reti issued with an empty stack leaves pc unchanged.
- R6: ext_pend is set at a clock edge where ext_pin is sampled 1 and was sampled 0 at the previous edge. A level held high does not set it again. tmr_pend is set at any edge where tmr_ovf is sampled 1.
- R7: An accepted external request stores the current pc on the stack and loads pc with 004H.
- R8: An accepted timer request stores the current pc on the stack and loads pc with 008H.
- R9: A request is accepted only when gie is 1, its own enable (ext_en or tmr_en) is 1, and stack_full is 0. Otherwise it stays pending and pc follows the flow inputs.
- R10: When both requests can be accepted in the same cycle, the external one is taken. The timer request stays pending.
- R11: In the cycle a request is accepted, gie is cleared, the serviced pending flag is cleared, and any flow input in that cycle is discarded.
- R12: reti pops the stack into pc and sets gie. When no request is accepted and no reti is given, gie_wr loads gie from gie_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc | input | 1 | Step to next word |
| jmp | input | 1 | Load target |
| call | input | 1 | Push pc+1, load target |
| ret | input | 1 | Pop into pc |
| reti | input | 1 | Pop into pc and set gie |
| target | input | 10 | Jump/call destination |
| gie_wr | input | 1 | Write global interrupt enable |
| gie_val | input | 1 | Value for gie_wr |
| ext_en | input | 1 | External source enable |
| tmr_en | input | 1 | Timer source enable |
| ext_pin | input | 1 | External request pin (synchronous) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| pc | output | 10 | Program counter |
| gie | output | 1 | Global interrupt enable |
| ext_pend | output | 1 | External request pending |
| tmr_pend | output | 1 | Timer request pending |
| stack_full | output | 1 | Stack holds DEPTH entries |
| push_err | output | 1 | Sticky refused-call flag |

## Verification
The bench uses the default parameters: a 10-bit counter, a stack of depth 2, and vectors at 000H, 004H and 008H. With a depth of two, the stack fills after only two calls, or after one call plus one interrupt. That makes the refused call, the interrupt held off by a full stack, and the later release after a return all short directed sequences. The 10-bit width keeps the 3FFH wrap within one jump and one step.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PC_W    = 10,
  parameter int DEPTH   = 2,
  parameter int RST_VEC = 0,
  parameter int EXT_VEC = 4,
  parameter int TMR_VEC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            jmp,
  input  logic            call,
  input  logic            ret,
  input  logic            reti,
  input  logic [PC_W-1:0] target,
  input  logic            gie_wr,
  input  logic            gie_val,
  input  logic            ext_en,
  input  logic            tmr_en,
  input  logic            ext_pin,
  input  logic            tmr_ovf,
  output logic [PC_W-1:0] pc,
  output logic            gie,
  output logic            ext_pend,
  output logic            tmr_pend,
  output logic            stack_full,
  output logic            push_err
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0] pc_q, pc_d, top, push_val;
  logic [PC_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic gie_q, ext_pend_q, tmr_pend_q, ext_pin_q, err_q;

  wire full   = (sp_q == SP_W'(DEPTH));
  wire empty  = (sp_q == '0);
  wire ext_ok = ext_pend_q & ext_en;
  wire tmr_ok = tmr_pend_q & tmr_en;
  wire take     = gie_q & ~full & (ext_ok | tmr_ok);
  wire take_ext = take & ext_ok;
  wire take_tmr = take & ~ext_ok;

  wire do_reti = ~take & reti;
  wire do_ret  = ~take & ~reti & ret;
  wire do_call = ~take & ~reti & ~ret & call;
  wire do_jmp  = ~take & ~reti & ~ret & ~call & jmp;
  wire do_inc  = ~take & ~reti & ~ret & ~call & ~jmp & inc;

  wire pop  = (do_reti | do_ret) & ~empty;
  wire push = take | (do_call & ~full);

  assign push_val = take ? pc_q : pc_q + 1'b1;

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top = stk[i];
  end

  always_comb begin
    pc_d = pc_q;
    if (take_ext)                pc_d = PC_W'(EXT_VEC);
    else if (take_tmr)           pc_d = PC_W'(TMR_VEC);
    else if (pop)                pc_d = top;
    else if (do_call && !full)   pc_d = target;
    else if (do_jmp)             pc_d = target;
    else if (do_inc)             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= PC_W'(RST_VEC);
      sp_q       <= '0;
      gie_q      <= 1'b0;
      ext_pend_q <= 1'b0;
      tmr_pend_q <= 1'b0;
      ext_pin_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      pc_q       <= pc_d;
      ext_pin_q  <= ext_pin;
      ext_pend_q <= (ext_pend_q & ~take_ext) | (ext_pin & ~ext_pin_q);
      tmr_pend_q <= (tmr_pend_q & ~take_tmr) | tmr_ovf;
      err_q      <= err_q | (do_call & full);
      if (push)     sp_q <= sp_q + 1'b1;
      else if (pop) sp_q <= sp_q - 1'b1;
      if (take)         gie_q <= 1'b0;
      else if (do_reti) gie_q <= 1'b1;
      else if (gie_wr)  gie_q <= gie_val;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           stk[g] <= '0;
      else if (push && sp_q == SP_W'(g))    stk[g] <= push_val;
    end
  end

  assign pc         = pc_q;
  assign gie        = gie_q;
  assign ext_pend   = ext_pend_q;
  assign tmr_pend   = tmr_pend_q;
  assign stack_full = full;
  assign push_err   = err_q;

  // R4
  sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !take);

  // R10
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_ext, take_tmr}));

  // R7
  ext_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |=> pc == PC_W'(EXT_VEC));

  // R8
  tmr_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_tmr |=> pc == PC_W'(TMR_VEC));

  // R11
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);

  // R12
  reti_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take) |=> gie);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(push_err) |-> push_err);
endmodule

// File: tb/sim_pc_seq.sv
`timescale 1ns/100ps
module sim_pc_seq;
  logic clk = 0, rst_n = 0;
  logic inc = 0, jmp = 0, call = 0, ret = 0, reti = 0;
  logic [9:0] target = '0;
  logic gie_wr = 0, gie_val = 0, ext_en = 0, tmr_en = 0, ext_pin = 0, tmr_ovf = 0;
  logic [9:0] pc;
  logic gie, ext_pend, tmr_pend, stack_full, push_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_seq u0 (.clk, .rst_n, .inc, .jmp, .call, .ret, .reti, .target,
             .gie_wr, .gie_val, .ext_en, .tmr_en, .ext_pin, .tmr_ovf,
             .pc, .gie, .ext_pend, .tmr_pend, .stack_full, .push_err);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    inc = 0; jmp = 0; call = 0; ret = 0; reti = 0; gie_wr = 0; tmr_ovf = 0;
  endtask

  task automatic go(logic [9:0] a);
    jmp = 1; target = a; cyc();
  endtask

  task automatic t_reset();
    rst_n = 0; #1;
    chk("R1 pc in reset", pc, 0);
    chk("R1 full in reset", stack_full, 0);
    repeat (2) @(posedge clk); #1;
    rst_n = 1; #1;
    chk("R1 pc", pc, 0); chk("R1 gie", gie, 0); chk("R1 err", push_err, 0);
    chk("R1 pend", {ext_pend, tmr_pend}, 0);
  endtask

  task automatic t_flow();
    inc = 1; cyc(); chk("R2 inc", pc, 1);
    cyc(); chk("R2 hold", pc, 1);
    inc = 1; jmp = 1; target = 10'h155; cyc(); chk("R2 jmp over inc", pc, 10'h155);
    go(10'h3FF); inc = 1; cyc(); chk("R2 wrap", pc, 0);
  endtask

  task automatic t_stack();
    go(10'h040);
    call = 1; target = 10'h100; cyc(); chk("R3 call1", pc, 10'h100);
    chk("R4 not full at 1", stack_full, 0);
    call = 1; target = 10'h200; cyc(); chk("R3 call2", pc, 10'h200);
    chk("R4 full at 2", stack_full, 1);
    call = 1; target = 10'h300; cyc();
    chk("R4 refused pc", pc, 10'h200); chk("R4 err", push_err, 1);
    ret = 1; cyc(); chk("R3 ret lifo", pc, 10'h101);
    ret = 1; cyc(); chk("R3 ret2", pc, 10'h041);
    chk("R4 empty", stack_full, 0);
    ret = 1; cyc(); chk("R5 ret empty", pc, 10'h041);
    reti = 1; cyc(); chk("R5 reti empty", pc, 10'h041);
    chk("R4 err sticky", push_err, 1);
    gie_wr = 1; gie_val = 0; cyc(); chk("R12 gie_wr", gie, 0);
  endtask

  task automatic t_ext();
    go(10'h020);
    gie_wr = 1; gie_val = 1; ext_en = 1; cyc(); chk("R12 gie write", gie, 1);
    ext_pin = 1; cyc();
    chk("R6 ext set", ext_pend, 1); chk("R9 not yet", pc, 10'h020);
    inc = 1; cyc();
    chk("R7 vector", pc, 10'h004); chk("R11 gie clr", gie, 0);
    chk("R11 pend clr", ext_pend, 0);
    cyc(); chk("R6 level no reset", ext_pend, 0);
    ext_pin = 0;
    reti = 1; cyc(); chk("R11 discarded inc", pc, 10'h020); chk("R12 reti gie", gie, 1);
    ext_en = 0;
  endtask

  task automatic t_tmr_gate();
    go(10'h060);
    tmr_en = 0; tmr_ovf = 1; cyc(); chk("R6 tmr set", tmr_pend, 1);
    cyc(); cyc(); chk("R9 en gate pc", pc, 10'h060); chk("R9 still pend", tmr_pend, 1);
    tmr_en = 1; cyc(); chk("R8 vector", pc, 10'h008); chk("R11 tmr clr", tmr_pend, 0);
    reti = 1; cyc(); chk("R8 return", pc, 10'h060);
  endtask

  task automatic t_full_gate();
    call = 1; target = 10'h110; cyc();
    call = 1; target = 10'h220; cyc();
    tmr_ovf = 1; cyc(); cyc();
    chk("R9 full gate pc", pc, 10'h220); chk("R9 full pend", tmr_pend, 1);
    ret = 1; cyc(); chk("R9 ret while pend", pc, 10'h111);
    cyc(); chk("R9 taken after room", pc, 10'h008);
    reti = 1; cyc(); chk("R9 back", pc, 10'h111);
    ret = 1; cyc(); chk("R3 final ret", pc, 10'h061);
  endtask

  task automatic t_prio();
    go(10'h0A0);
    gie_wr = 1; gie_val = 0; ext_en = 1; tmr_en = 1; ext_pin = 1; tmr_ovf = 1; cyc();
    chk("R9 gie gate", pc, 10'h0A0);
    ext_pin = 0; gie_wr = 1; gie_val = 1; cyc();
    chk("R10 both pend", {ext_pend, tmr_pend}, 3);
    cyc(); chk("R10 ext first", pc, 10'h004); chk("R10 tmr kept", tmr_pend, 1);
    reti = 1; cyc(); chk("R12 reti pop", pc, 10'h0A0);
    cyc(); chk("R10 tmr next", pc, 10'h008);
    reti = 1; cyc(); chk("R10 final", pc, 10'h0A0);
  endtask

  initial begin
    t_reset(); t_flow(); t_stack(); t_ext(); t_tmr_gate(); t_full_gate(); t_prio();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule